// File: doc/BRIEF.md
# Execute-Stage Redirect and Squash Selector

This block sits after the execute lanes of an out-of-order core. Each cycle it looks at up to `LANES` finished results and decides, for each hardware thread, whether commit must be told to squash and restart fetch. Three causes can ask for a redirect: a resolved branch whose predicted path was wrong, a load that broke memory ordering, and a load that the memory system could not accept and that has not yet been handled. Results arrive oldest first. Within a cycle, only the first redirecting result of a thread is acted on. Any younger event from the same thread is dropped, because the squash it would ask for is already covered.

For each thread, the selector builds a registered squash packet. The packet holds the sequence number to squash from, the PC to restart at, and a flag that says whether the squashing instruction itself is discarded. For a wrong branch, the packet also holds the branch PC, a mispredict flag and the resolved direction. The block acknowledges the causes it acts on, so the load/store logic can drop a consumed ordering violation or mark a blocked load as handled. It also keeps two mispredict counters: one for wrong predicted-taken branches and one for wrong predicted-not-taken branches.

Top module: `exe_redirect_sel`

## Requirements
- R1: Per thread, at most one redirect is taken per cycle: the lowest-numbered lane with a redirecting cause for that thread. Later lanes of the same thread in that cycle get no acknowledge and do not change the packet.
- R2: Within one result, the causes rank as mispredict (`res_misp`), then ordering violation (`res_viol`), then unhandled blocked load (`res_blk` with `res_blk_done` = 0). Only the highest present cause is acted on: it sets `sq_misp` to 1 only for a mispredict, and only it is acknowledged.
- R3: A mispredict packet carries the result's sequence number, `sq_bpc` = its PC, `sq_npc` = its next PC, `sq_misp` = 1, `sq_incl` = 0 and `sq_taken` = 1 exactly when next PC differs from PC + `ILEN` (modulo 2^`PCW`).
- R4: An ordering-violation packet carries the sequence number, `sq_npc` = next PC, `sq_incl` = 0, `sq_misp` = 0, `sq_taken` = 0, `sq_bpc` = 0. In that same cycle, `viol_take` is raised for that lane.
- R5: A blocked-load packet carries the sequence number, `sq_npc` = the load's own PC, `sq_incl` = 1 and `sq_misp`/`sq_taken`/`sq_bpc` = 0. In that same cycle, `blk_mark` is raised for that lane. A blocked load with `res_blk_done` = 1 causes nothing.
- R6: Each taken mispredict with `sq_taken` = 1 adds one to `cnt_pnt_wrong`. Each taken mispredict with `sq_taken` = 0 adds one to `cnt_pt_wrong`. Both counters update on the same edge as the packet.
- R7: A valid result with `res_sqd` = 1 raises `res_commit_ok` in that cycle. It never causes a redirect or an acknowledge, and it does not hold back a later lane of its thread.
- R8: Packets are registered. They appear on the edge after the results and are valid for exactly that one cycle. When `sq_vld` = 0, every field of that thread reads 0.
- R9: While reset is active, all packet outputs and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| res_vld | input | LANES | Result present in lane |
| res_tid | input | LANES*TW | Thread of each lane |
| res_seq | input | LANES*SEQW | Sequence number of each lane |
| res_pc | input | LANES*PCW | Instruction PC of each lane |
| res_npc | input | LANES*PCW | Resolved next PC of each lane |
| res_sqd | input | LANES | Result already squashed |
| res_misp | input | LANES | Branch resolved against its prediction |
| res_viol | input | LANES | Memory-order violation flagged |
| res_blk | input | LANES | Load blocked by memory |
| res_blk_done | input | LANES | Blocked load already handled |
| res_commit_ok | output | LANES | Squashed result treated as executed and committable |
| viol_take | output | LANES | Violation consumed by a redirect |
| blk_mark | output | LANES | Blocked load to be marked handled |
| sq_vld | output | NT | Squash packet valid per thread |
| sq_seq | output | NT*SEQW | Squash sequence number |
| sq_npc | output | NT*PCW | Restart PC |
| sq_bpc | output | NT*PCW | Mispredicted branch PC |
| sq_misp | output | NT | Packet from a mispredict |
| sq_taken | output | NT | Branch resolved taken |
| sq_incl | output | NT | Squashing instruction is itself discarded |
| cnt_pt_wrong | output | CNTW | Wrong predicted-taken count |
| cnt_pnt_wrong | output | CNTW | Wrong predicted-not-taken count |

## Verification
The acknowledges (`viol_take`, `blk_mark`, `res_commit_ok`) depend only on the current lane inputs. They are sampled one time unit after the inputs change, in the same cycle and before the next edge. The packet and the counters go through one register each. Their expected values are worked out when the inputs are driven and then compared just after the following rising edge, and the bench changes the inputs only at falling edges. A one-cycle-valid packet is confirmed by every stimulus cycle that has no events for a thread, which must show that thread's packet at zero.

// File: rtl/exe_redirect_sel.sv
module exe_redirect_sel #(
  parameter int NT    = 2,
  parameter int LANES = 4,
  parameter int SEQW  = 8,
  parameter int PCW   = 16,
  parameter int ILEN  = 4,
  parameter int CNTW  = 16,
  localparam int TW   = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      res_vld,
  input  logic [LANES*TW-1:0]   res_tid,
  input  logic [LANES*SEQW-1:0] res_seq,
  input  logic [LANES*PCW-1:0]  res_pc,
  input  logic [LANES*PCW-1:0]  res_npc,
  input  logic [LANES-1:0]      res_sqd,
  input  logic [LANES-1:0]      res_misp,
  input  logic [LANES-1:0]      res_viol,
  input  logic [LANES-1:0]      res_blk,
  input  logic [LANES-1:0]      res_blk_done,
  output logic [LANES-1:0]      res_commit_ok,
  output logic [LANES-1:0]      viol_take,
  output logic [LANES-1:0]      blk_mark,
  output logic [NT-1:0]         sq_vld,
  output logic [NT*SEQW-1:0]    sq_seq,
  output logic [NT*PCW-1:0]     sq_npc,
  output logic [NT*PCW-1:0]     sq_bpc,
  output logic [NT-1:0]         sq_misp,
  output logic [NT-1:0]         sq_taken,
  output logic [NT-1:0]         sq_incl,
  output logic [CNTW-1:0]       cnt_pt_wrong,
  output logic [CNTW-1:0]       cnt_pnt_wrong
);

  logic [NT-1:0]      redir;
  logic [NT-1:0]      n_vld, n_misp, n_taken, n_incl;
  logic [NT*SEQW-1:0] n_seq;
  logic [NT*PCW-1:0]  n_npc, n_bpc;
  logic [LANES-1:0]   hit_m;
  logic [CNTW-1:0]    add_pt, add_pnt;
  logic [PCW-1:0]     l_pc, l_npc;
  int                 t;

  assign res_commit_ok = res_vld & res_sqd;

  always_comb begin
    redir = '0; n_vld = '0; n_misp = '0; n_taken = '0; n_incl = '0;
    n_seq = '0; n_npc = '0; n_bpc = '0;
    hit_m = '0; viol_take = '0; blk_mark = '0;
    l_pc = '0; l_npc = '0; t = 0;
    for (int i = 0; i < LANES; i++) begin
      t     = int'(res_tid[i*TW +: TW]);
      l_pc  = res_pc[i*PCW +: PCW];
      l_npc = res_npc[i*PCW +: PCW];
      if (res_vld[i] && !res_sqd[i] && t < NT && !redir[t]) begin
        if (res_misp[i])                         hit_m[i]     = 1'b1;
        else if (res_viol[i])                    viol_take[i] = 1'b1;
        else if (res_blk[i] && !res_blk_done[i]) blk_mark[i]  = 1'b1;
        if (hit_m[i] || viol_take[i] || blk_mark[i]) begin
          redir[t]              = 1'b1;
          n_vld[t]              = 1'b1;
          n_seq[t*SEQW +: SEQW] = res_seq[i*SEQW +: SEQW];
          n_npc[t*PCW +: PCW]   = blk_mark[i] ? l_pc : l_npc;
          n_bpc[t*PCW +: PCW]   = hit_m[i] ? l_pc : '0;
          n_misp[t]             = hit_m[i];
          n_taken[t]            = hit_m[i] && (l_npc != l_pc + PCW'(ILEN));
          n_incl[t]             = blk_mark[i];
        end
      end
    end
  end

  always_comb begin
    add_pt = '0; add_pnt = '0;
    for (int k = 0; k < NT; k++) begin
      if (n_misp[k] && n_taken[k])  add_pnt = add_pnt + 1'b1;
      if (n_misp[k] && !n_taken[k]) add_pt  = add_pt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_vld <= '0; sq_seq <= '0; sq_npc <= '0; sq_bpc <= '0;
      sq_misp <= '0; sq_taken <= '0; sq_incl <= '0;
      cnt_pt_wrong <= '0; cnt_pnt_wrong <= '0;
    end else begin
      sq_vld <= n_vld; sq_seq <= n_seq; sq_npc <= n_npc; sq_bpc <= n_bpc;
      sq_misp <= n_misp; sq_taken <= n_taken; sq_incl <= n_incl;
      cnt_pt_wrong  <= cnt_pt_wrong + add_pt;
      cnt_pnt_wrong <= cnt_pnt_wrong + add_pnt;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_quiet_sqd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld[g] && res_sqd[g]) |-> !viol_take[g] && !blk_mark[g]);
    p_viol_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      viol_take[g] |-> res_viol[g] && !res_misp[g] && !blk_mark[g]);
    p_blk_rank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      blk_mark[g] |-> res_blk[g] && !res_blk_done[g] && !res_misp[g] && !res_viol[g]);
  end

  for (genvar h = 0; h < NT; h++) begin : g_thr_chk
    p_taken_misp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sq_taken[h] |-> sq_misp[h] && sq_vld[h]);
    p_incl_blk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sq_incl[h] |-> sq_vld[h] && !sq_misp[h]);
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sq_vld[h] |-> sq_seq[h*SEQW +: SEQW] == '0 && sq_npc[h*PCW +: PCW] == '0);
  end

  p_cnt_pt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sq_misp & ~sq_taken)) |-> $stable(cnt_pt_wrong));
  p_cnt_pnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sq_misp & sq_taken)) |-> $stable(cnt_pnt_wrong));

endmodule

// File: tb/sim_exe_redirect_sel.sv
`timescale 1ns/1ps
module sim_exe_redirect_sel;
  localparam int NT = 2, L = 4, SW = 8, PW = 12, IL = 4, CW = 16, TW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          b_vld [L], b_sqd [L], b_misp [L], b_viol [L], b_blk [L], b_done [L];
  logic [TW-1:0] b_tid [L];
  logic [SW-1:0] b_seq [L];
  logic [PW-1:0] b_pc [L], b_npc [L];

  logic [L-1:0] res_vld, res_sqd, res_misp, res_viol, res_blk, res_blk_done;
  logic [L*TW-1:0] res_tid;
  logic [L*SW-1:0] res_seq;
  logic [L*PW-1:0] res_pc, res_npc;
  logic [L-1:0] res_commit_ok, viol_take, blk_mark;
  logic [NT-1:0] sq_vld, sq_misp, sq_taken, sq_incl;
  logic [NT*SW-1:0] sq_seq;
  logic [NT*PW-1:0] sq_npc, sq_bpc;
  logic [CW-1:0] cnt_pt_wrong, cnt_pnt_wrong;

  always_comb
    for (int i = 0; i < L; i++) begin
      res_vld[i] = b_vld[i]; res_sqd[i] = b_sqd[i]; res_misp[i] = b_misp[i];
      res_viol[i] = b_viol[i]; res_blk[i] = b_blk[i]; res_blk_done[i] = b_done[i];
      res_tid[i*TW +: TW] = b_tid[i]; res_seq[i*SW +: SW] = b_seq[i];
      res_pc[i*PW +: PW] = b_pc[i]; res_npc[i*PW +: PW] = b_npc[i];
    end

  exe_redirect_sel #(.NT(NT), .LANES(L), .SEQW(SW), .PCW(PW), .ILEN(IL), .CNTW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_tid(res_tid), .res_seq(res_seq),
    .res_pc(res_pc), .res_npc(res_npc), .res_sqd(res_sqd), .res_misp(res_misp),
    .res_viol(res_viol), .res_blk(res_blk), .res_blk_done(res_blk_done),
    .res_commit_ok(res_commit_ok), .viol_take(viol_take), .blk_mark(blk_mark),
    .sq_vld(sq_vld), .sq_seq(sq_seq), .sq_npc(sq_npc), .sq_bpc(sq_bpc),
    .sq_misp(sq_misp), .sq_taken(sq_taken), .sq_incl(sq_incl),
    .cnt_pt_wrong(cnt_pt_wrong), .cnt_pnt_wrong(cnt_pnt_wrong));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'hACE1_2024;
  logic [CW-1:0] e_pt = '0, e_pnt = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < L; i++) begin
      b_vld[i] = 0; b_sqd[i] = 0; b_misp[i] = 0; b_viol[i] = 0; b_blk[i] = 0;
      b_done[i] = 0; b_tid[i] = '0; b_seq[i] = '0; b_pc[i] = '0; b_npc[i] = '0;
    end
  endtask

  task automatic set_lane(int i, int tid, int sqd, int mp, int vi, int bl, int dn,
                          int seq, int pc, int npc);
    b_vld[i] = 1; b_tid[i] = TW'(tid); b_sqd[i] = sqd[0]; b_misp[i] = mp[0];
    b_viol[i] = vi[0]; b_blk[i] = bl[0]; b_done[i] = dn[0];
    b_seq[i] = SW'(seq); b_pc[i] = PW'(pc); b_npc[i] = PW'(npc);
  endtask

  // Inputs already driven after a falling edge; check both stages of the result.
  task automatic evaluate();
    logic [L-1:0] x_vt, x_bm, x_ok;
    logic          x_v [NT], x_m [NT], x_t [NT], x_i [NT];
    logic [SW-1:0] x_s [NT];
    logic [PW-1:0] x_n [NT], x_b [NT];
    bit            took [NT];
    x_vt = '0; x_bm = '0; x_ok = '0;
    for (int k = 0; k < NT; k++) begin
      x_v[k] = 0; x_m[k] = 0; x_t[k] = 0; x_i[k] = 0; x_s[k] = '0; x_n[k] = '0; x_b[k] = '0;
      took[k] = 0;
    end
    for (int i = 0; i < L; i++) begin
      int k;
      k = int'(b_tid[i]);
      if (b_vld[i] && b_sqd[i]) x_ok[i] = 1;
      if (b_vld[i] && !b_sqd[i] && !took[k]) begin
        if (b_misp[i]) begin
          took[k] = 1; x_v[k] = 1; x_m[k] = 1; x_s[k] = b_seq[i];
          x_n[k] = b_npc[i]; x_b[k] = b_pc[i];
          x_t[k] = (int'(b_npc[i]) != ((int'(b_pc[i]) + IL) % (1 << PW)));
        end else if (b_viol[i]) begin
          took[k] = 1; x_v[k] = 1; x_s[k] = b_seq[i]; x_n[k] = b_npc[i]; x_vt[i] = 1;
        end else if (b_blk[i] && !b_done[i]) begin
          took[k] = 1; x_v[k] = 1; x_s[k] = b_seq[i]; x_n[k] = b_pc[i]; x_i[k] = 1;
          x_bm[i] = 1;
        end
      end
    end
    #1;
    chk("R4 viol_take", 32'(viol_take), 32'(x_vt));
    chk("R5 blk_mark", 32'(blk_mark), 32'(x_bm));
    chk("R7 res_commit_ok", 32'(res_commit_ok), 32'(x_ok));
    for (int k = 0; k < NT; k++)
      if (x_m[k]) begin
        if (x_t[k]) e_pnt = e_pnt + 1'b1; else e_pt = e_pt + 1'b1;
      end
    @(posedge clk); #1;
    for (int k = 0; k < NT; k++) begin
      chk("R8 sq_vld", 32'(sq_vld[k]), 32'(x_v[k]));
      chk("R1 sq_seq", 32'(sq_seq[k*SW +: SW]), 32'(x_s[k]));
      chk("R3 sq_npc", 32'(sq_npc[k*PW +: PW]), 32'(x_n[k]));
      chk("R3 sq_bpc", 32'(sq_bpc[k*PW +: PW]), 32'(x_b[k]));
      chk("R2 sq_misp", 32'(sq_misp[k]), 32'(x_m[k]));
      chk("R3 sq_taken", 32'(sq_taken[k]), 32'(x_t[k]));
      chk("R5 sq_incl", 32'(sq_incl[k]), 32'(x_i[k]));
    end
    chk("R6 cnt_pt_wrong", 32'(cnt_pt_wrong), 32'(e_pt));
    chk("R6 cnt_pnt_wrong", 32'(cnt_pnt_wrong), 32'(e_pnt));
    @(negedge clk);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    clear_lanes();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 sq_vld", 32'(sq_vld), 0);
    chk("R9 sq_seq", 32'(sq_seq), 0);
    chk("R9 cnt_pt", 32'(cnt_pt_wrong), 0);
    chk("R9 cnt_pnt", 32'(cnt_pnt_wrong), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: first event per thread wins; later same-thread events are dropped
    clear_lanes();
    set_lane(0, 0, 0, 1, 0, 0, 0, 8'h11, 12'h100, 12'h200);
    set_lane(1, 0, 0, 0, 1, 0, 0, 8'h12, 12'h104, 12'h108);
    set_lane(2, 1, 0, 0, 0, 1, 0, 8'h21, 12'h300, 12'h304);
    set_lane(3, 1, 0, 1, 0, 0, 0, 8'h22, 12'h310, 12'h400);
    evaluate();
    // R2: all causes in one result -> mispredict, not taken
    clear_lanes();
    set_lane(1, 1, 0, 1, 1, 1, 0, 8'h33, 12'h500, 12'h504);
    set_lane(2, 0, 0, 0, 1, 1, 0, 8'h34, 12'h600, 12'h700);
    evaluate();
    // R5: handled blocked load has no effect; R7: squashed results are quiet
    clear_lanes();
    set_lane(0, 0, 0, 0, 0, 1, 1, 8'h41, 12'h010, 12'h014);
    set_lane(1, 0, 1, 1, 1, 1, 0, 8'h42, 12'h020, 12'h090);
    set_lane(2, 0, 0, 0, 0, 1, 0, 8'h43, 12'h030, 12'h034);
    set_lane(3, 1, 1, 1, 0, 0, 0, 8'h44, 12'h040, 12'h080);
    evaluate();
    // R8: idle cycle clears packet; R3: PC wrap-around for taken
    clear_lanes();
    evaluate();
    clear_lanes();
    set_lane(0, 1, 0, 1, 0, 0, 0, 8'h55, 12'hFFC, 12'h000);
    set_lane(1, 0, 0, 1, 0, 0, 0, 8'h56, 12'hFFE, 12'h000);
    evaluate();

    // Sweep of lane patterns
    for (int c = 0; c < 4000; c++) begin
      clear_lanes();
      for (int i = 0; i < L; i++) begin
        lfsr = nxt(lfsr); lfsr = nxt(lfsr); lfsr = nxt(lfsr);
        b_vld[i]  = lfsr[0] | lfsr[1];
        b_tid[i]  = lfsr[2];
        b_sqd[i]  = (lfsr[5:3] == 3'd0);
        b_misp[i] = (lfsr[7:6] == 2'd0);
        b_viol[i] = (lfsr[9:8] == 2'd0);
        b_blk[i]  = (lfsr[11:10] != 2'd3);
        b_done[i] = lfsr[12];
        b_seq[i]  = lfsr[20:13];
        b_pc[i]   = {lfsr[30:21], 2'b00};
        b_npc[i]  = lfsr[31] ? b_pc[i] + 12'd4 : {lfsr[9:0], lfsr[23:22]};
      end
      evaluate();
    end
    finish_run();
  end
endmodule